// File: doc/BRIEF.md
# Byte-Field Load/Store Aligner

This block moves a byte field between a memory word and a register in a word-oriented datapath. A word carries one sign bit and five 6-bit magnitude bytes. A field is picked by a pair of positions L and R. Position 0 is the sign and positions 1 to 5 are the magnitude bytes, most significant first.

For a load, the chosen field of the memory word is right-justified into a register image, and a variant inverts the sign. For a store, the low-order bytes of the register are written into positions L to R of the old memory word, and every byte outside the field is kept. Two store variants exist. One always writes a plus sign. The other writes plus zero into the whole field.

The caller gives an operation code, the packed field selector, the register value and the old memory word together with a start strobe. One clock later the block returns the new register or memory word, a valid pulse and an invalid-field flag. Address generation, memory access and instruction decode are left to the surrounding pipeline.

Top module: `field_aligner`

## Requirements
- R1: A word is 31 bits. Bit 30 is the sign (1 = minus). Magnitude position p (1..5) occupies bits [(5-p)*6 +: 6], so position 1 is the most significant byte.
- R2: The field selector `fsel` is 8L+R: L = fsel[5:3] and R = fsel[2:0].
- R3: Load (op 0): bytes max(L,1)..R of `mem_in` appear at positions 5-R+max(L,1)..5 of `result`, and all higher positions are zero. The sign is the word sign when L = 0 and plus otherwise.
- R4: Negated load (op 1): same as R3, but the resulting sign is inverted. This includes fields that leave out position 0, which then give minus.
- R5: Store (op 2): each word position q in max(L,1)..R takes register position q+5-R. The sign takes the register sign when L = 0. All other positions of `mem_in` pass through unchanged.
- R6: Jump-register store (op 3): same as R5, except that the sign written when L = 0 is always plus.
- R7: Zero store (op 4): the field's magnitude bytes become zero, and the sign becomes plus when L = 0. The rest of `mem_in` is kept.
- R8: A field with L > R or R > 5 sets `bad_field`. The destination then comes back unchanged: `reg_in` for load ops (0, 1, 5..7) and `mem_in` for store ops (2..4).
- R9: `result`, `valid` and `bad_field` update on the clock edge that samples `start` high. `valid` is high only in the cycle after a start. Without a start, `result` holds its value.
- R10: While `rst` is high, `result`, `valid` and `bad_field` are cleared to zero.
- R11: Op codes 5, 6 and 7 behave exactly as a plain load (op 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the operands and compute a result |
| op_sel | input | 3 | Operation code (0 load, 1 negated load, 2 store, 3 jump store, 4 zero store) |
| fsel | input | 6 | Field selector 8L+R |
| reg_in | input | 31 | Register value |
| mem_in | input | 31 | Old memory word |
| result | output | 31 | New register image (load) or memory word (store) |
| valid | output | 1 | One-cycle pulse marking a fresh result |
| bad_field | output | 1 | Last started operation named an illegal field |

## Verification
The checks start with a table of hand-worked cases. These use one fixed register and memory pair with distinct byte values, so a byte taken from the wrong position or shifted by the wrong amount shows up as a wrong number. The table covers whole-word, sign-only, single-byte and interior fields. A negative memory word paired with a negative register separates sign sourcing from sign forcing across the load and the store variants. An exhaustive sweep then runs all 64 selector codes against all eight op codes with two operand pairs, one of them dense with set bits. The sweep catches errors in mask edges and in the shift amount, and it shows whether illegal fields fall back to the right destination. Directed steps cover reset and an idle hold.

// File: rtl/fw_pkg.sv
package fw_pkg;

    localparam int BYTE_W = 6;
    localparam int NBYTES = 5;
    localparam int POS_W  = $clog2(NBYTES + 1);
    localparam int FSEL_W = 2 * POS_W;
    localparam int MAG_W  = BYTE_W * NBYTES;
    localparam int WORD_W = MAG_W + 1;
    localparam int OP_W   = 3;

    typedef logic [1:NBYTES][BYTE_W-1:0] mag_t;

    typedef struct packed {
        logic sign;
        mag_t mag;
    } word_t;

    localparam logic [OP_W-1:0] OP_LD  = 3'd0;
    localparam logic [OP_W-1:0] OP_LDN = 3'd1;
    localparam logic [OP_W-1:0] OP_ST  = 3'd2;
    localparam logic [OP_W-1:0] OP_STJ = 3'd3;
    localparam logic [OP_W-1:0] OP_STZ = 3'd4;

    typedef struct packed {
        logic [POS_W-1:0] lo;
        logic [POS_W-1:0] hi;
        logic             bad;
        logic             has_sign;
        logic [1:NBYTES]  bmask;
        logic [POS_W-1:0] shift;
    } fdec_t;

    function automatic logic is_store(input logic [OP_W-1:0] op);
        return (op == OP_ST) || (op == OP_STJ) || (op == OP_STZ);
    endfunction

    function automatic mag_t expand_mask(input logic [1:NBYTES] bm);
        mag_t m;
        for (int p = 1; p <= NBYTES; p++) begin
            m[p] = {BYTE_W{bm[p]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/fw_field_decode.sv
module fw_field_decode
    import fw_pkg::*;
(
    input  logic [FSEL_W-1:0] fsel,
    output fdec_t             dec
);
    logic [POS_W-1:0] lo;
    logic [POS_W-1:0] hi;
    logic [1:NBYTES]  bm;

    assign lo = fsel[FSEL_W-1:POS_W];
    assign hi = fsel[POS_W-1:0];

    for (genvar p = 1; p <= NBYTES; p++) begin : g_pos
        assign bm[p] = (POS_W'(p) >= lo) && (POS_W'(p) <= hi);
    end

    always_comb begin
        dec.lo       = lo;
        dec.hi       = hi;
        dec.bad      = (lo > hi) || (hi > POS_W'(NBYTES));
        dec.has_sign = (lo == '0);
        dec.bmask    = bm;
        dec.shift    = POS_W'(NBYTES) - hi;
    end
endmodule

// File: rtl/fw_load_unit.sv
module fw_load_unit
    import fw_pkg::*;
(
    input  word_t mem_w,
    input  fdec_t dec,
    input  logic  negate,
    output word_t out_w
);
    logic [MAG_W-1:0] masked;
    logic [MAG_W-1:0] aligned;

    always_comb begin
        masked    = mem_w.mag & expand_mask(dec.bmask);
        aligned   = masked >> (32'(dec.shift) * BYTE_W);
        out_w.mag = mag_t'(aligned);
        out_w.sign = (dec.has_sign & mem_w.sign) ^ negate;
    end
endmodule

// File: rtl/fw_store_unit.sv
module fw_store_unit
    import fw_pkg::*;
(
    input  word_t           reg_w,
    input  word_t           old_w,
    input  fdec_t           dec,
    input  logic [OP_W-1:0] op,
    output word_t           out_w
);
    logic [MAG_W-1:0] fill;
    logic [MAG_W-1:0] msk;

    always_comb begin
        msk = expand_mask(dec.bmask);
        if (op == OP_STZ) begin
            fill = '0;
        end else begin
            fill = reg_w.mag << (32'(dec.shift) * BYTE_W);
        end
        out_w.mag = mag_t'((old_w.mag & ~msk) | (fill & msk));
        if (!dec.has_sign) begin
            out_w.sign = old_w.sign;
        end else if (op == OP_ST) begin
            out_w.sign = reg_w.sign;
        end else begin
            out_w.sign = 1'b0;
        end
    end
endmodule

// File: rtl/field_aligner.sv
module field_aligner
    import fw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [WORD_W-1:0] reg_in,
    input  logic [WORD_W-1:0] mem_in,
    output logic [WORD_W-1:0] result,
    output logic              valid,
    output logic              bad_field
);
    fdec_t dec;
    word_t ld_w;
    word_t st_w;
    word_t nxt_w;
    logic  st_op;

    fw_field_decode u_dec (
        .fsel (fsel),
        .dec  (dec)
    );

    fw_load_unit u_load (
        .mem_w  (word_t'(mem_in)),
        .dec    (dec),
        .negate (op_sel == OP_LDN),
        .out_w  (ld_w)
    );

    fw_store_unit u_store (
        .reg_w (word_t'(reg_in)),
        .old_w (word_t'(mem_in)),
        .dec   (dec),
        .op    (op_sel),
        .out_w (st_w)
    );

    always_comb begin
        st_op = is_store(op_sel);
        if (dec.bad) begin
            nxt_w = st_op ? word_t'(mem_in) : word_t'(reg_in);
        end else begin
            nxt_w = st_op ? st_w : ld_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            valid     <= 1'b0;
            bad_field <= 1'b0;
        end else begin
            valid <= start;
            if (start) begin
                result    <= nxt_w;
                bad_field <= dec.bad;
            end
        end
    end
endmodule

// File: rtl/fa_checker.sv
module fa_checker
    import fw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   op_sel,
    input logic [FSEL_W-1:0] fsel,
    input logic [WORD_W-1:0] reg_in,
    input logic [WORD_W-1:0] mem_in,
    input logic [WORD_W-1:0] result,
    input logic              valid,
    input logic              bad_field
);
    logic illegal;
    logic st_kind;
    assign illegal = (fsel[FSEL_W-1:POS_W] > fsel[POS_W-1:0]) ||
                     (fsel[POS_W-1:0] > POS_W'(NBYTES));
    assign st_kind = (op_sel == OP_ST) || (op_sel == OP_STJ) || (op_sel == OP_STZ);

    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!valid && $stable(result)));

    p_bad_store_r8: assert property (@(posedge clk) disable iff (rst)
        (start && illegal && st_kind) |=> (bad_field && result == $past(mem_in)));

    p_bad_load_r8: assert property (@(posedge clk) disable iff (rst)
        (start && illegal && !st_kind) |=> (bad_field && result == $past(reg_in)));

    p_zero_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !illegal && op_sel == OP_STZ && fsel[FSEL_W-1:POS_W] == '0)
        |=> !result[WORD_W-1]);

    p_plus_load_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !illegal && op_sel == OP_LD && fsel[FSEL_W-1:POS_W] != '0)
        |=> !result[WORD_W-1]);
endmodule

bind field_aligner fa_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_sel    (op_sel),
    .fsel      (fsel),
    .reg_in    (reg_in),
    .mem_in    (mem_in),
    .result    (result),
    .valid     (valid),
    .bad_field (bad_field)
);

// File: tb/test_field_aligner.sv
`timescale 1ns/1ps
module test_field_aligner;
    import fw_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [OP_W-1:0]   op_sel = '0;
    logic [FSEL_W-1:0] fsel = '0;
    logic [WORD_W-1:0] reg_in = '0;
    logic [WORD_W-1:0] mem_in = '0;
    logic [WORD_W-1:0] result;
    logic              valid;
    logic              bad_field;

    int n_total = 0;
    int n_bad   = 0;

    always #2.5 clk = ~clk;

    field_aligner i_field_aligner (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .fsel(fsel),
        .reg_in(reg_in), .mem_in(mem_in), .result(result), .valid(valid),
        .bad_field(bad_field)
    );

    localparam logic [WORD_W-1:0] RW0 = {1'b1, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14};
    localparam logic [WORD_W-1:0] MW0 = {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
    localparam logic [WORD_W-1:0] RW1 = {1'b0, 6'd63, 6'd0, 6'd42, 6'd7, 6'd21};
    localparam logic [WORD_W-1:0] MW1 = {1'b0, 6'd33, 6'd63, 6'd17, 6'd60, 6'd9};

    // entry: {op, fsel, expected word, expected bad}
    localparam int NV = 16;
    localparam logic [40:0] VEC [NV] = '{
        {3'd0, 6'd5,  1'b1, 6'd1,  6'd2,  6'd3,  6'd4,  6'd5,  1'b0},
        {3'd0, 6'd13, 1'b0, 6'd1,  6'd2,  6'd3,  6'd4,  6'd5,  1'b0},
        {3'd0, 6'd27, 1'b0, 6'd0,  6'd0,  6'd0,  6'd0,  6'd3,  1'b0},
        {3'd0, 6'd0,  1'b1, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  1'b0},
        {3'd1, 6'd2,  1'b0, 6'd0,  6'd0,  6'd0,  6'd1,  6'd2,  1'b0},
        {3'd1, 6'd37, 1'b1, 6'd0,  6'd0,  6'd0,  6'd4,  6'd5,  1'b0},
        {3'd2, 6'd5,  1'b1, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 1'b0},
        {3'd2, 6'd10, 1'b1, 6'd13, 6'd14, 6'd3,  6'd4,  6'd5,  1'b0},
        {3'd2, 6'd1,  1'b1, 6'd14, 6'd2,  6'd3,  6'd4,  6'd5,  1'b0},
        {3'd3, 6'd3,  1'b0, 6'd12, 6'd13, 6'd14, 6'd4,  6'd5,  1'b0},
        {3'd4, 6'd20, 1'b1, 6'd1,  6'd0,  6'd0,  6'd0,  6'd5,  1'b0},
        {3'd4, 6'd1,  1'b0, 6'd0,  6'd2,  6'd3,  6'd4,  6'd5,  1'b0},
        {3'd2, 6'd27, 1'b1, 6'd1,  6'd2,  6'd14, 6'd4,  6'd5,  1'b0},
        {3'd0, 6'd54, 1'b1, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 1'b1},
        {3'd2, 6'd26, 1'b1, 6'd1,  6'd2,  6'd3,  6'd4,  6'd5,  1'b1},
        {3'd5, 6'd13, 1'b0, 6'd1,  6'd2,  6'd3,  6'd4,  6'd5,  1'b0}
    };

    function automatic string req_of(input logic [2:0] op, input logic bad);
        if (bad) return "R8";
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R11";
        endcase
    endfunction

    // Independent model built position by position from the requirements.
    function automatic logic [WORD_W:0] ref_model(input logic [2:0] op, input logic [5:0] f,
                                                  input word_t rw, input word_t mw);
        int l = int'(f[5:3]);
        int r = int'(f[2:0]);
        word_t o;
        logic st = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
        if (l > r || r > 5) return {1'b1, st ? mw : rw};
        if (!st) begin
            o = '0;
            for (int k = 0; k <= 5; k++) begin
                if (k >= l && k <= r) begin
                    if (k == 0) o.sign = mw.sign;
                    else o.mag[5 - r + k] = mw.mag[k];
                end
            end
            if (op == 3'd1) o.sign = ~o.sign;
        end else begin
            o = mw;
            for (int k = 0; k <= 5; k++) begin
                if (k >= l && k <= r) begin
                    if (k == 0) o.sign = (op == 3'd2) ? rw.sign : 1'b0;
                    else o.mag[k] = (op == 3'd4) ? 6'd0 : rw.mag[k + 5 - r];
                end
            end
        end
        return {1'b0, o};
    endfunction

    task automatic check(input string req, input logic [WORD_W:0] got, input logic [WORD_W:0] exp);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive on a falling edge; result is registered on the next rising edge, sampled on the following fall.
    task automatic run_op(input logic [2:0] op, input logic [5:0] f,
                          input logic [WORD_W-1:0] rw, input logic [WORD_W-1:0] mw,
                          output logic [WORD_W:0] got, output logic vld);
        @(negedge clk);
        op_sel = op; fsel = f; reg_in = rw; mem_in = mw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = {bad_field, result};
        vld = valid;
    endtask

    initial begin
        #(200000 * 5);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        logic [WORD_W:0] got;
        logic [WORD_W:0] held;
        logic            vld;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {valid, bad_field, result}, '0);
        rst = 1'b0;

        // Table of hand-worked vectors
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][40:38], VEC[i][37:32], RW0, MW0, got, vld);
            check(req_of(VEC[i][40:38], VEC[i][0]), got, {VEC[i][0], VEC[i][31:1]});
            check("R9", {31'd0, vld}, {31'd0, 1'b1});
        end

        // R1: byte position 5 lands in bits [5:0], position 1 in bits [29:24]
        run_op(3'd0, 6'd45, RW0, MW0, got, vld);
        check("R1", {26'd0, got[5:0]}, {26'd0, 6'd5});
        run_op(3'd0, 6'd9, RW0, MW0, got, vld);
        check("R1", {26'd0, got[5:0]}, {26'd0, 6'd1});

        // R2 sweep: every selector code with every op code, two operand pairs
        for (int f = 0; f < 64; f++) begin
            for (int op = 0; op < 8; op++) begin
                run_op(3'(op), 6'(f), RW0, MW0, got, vld);
                check($sformatf("R2 %s f=%0d op=%0d", req_of(3'(op), got[WORD_W]), f, op),
                      got, ref_model(3'(op), 6'(f), RW0, MW0));
                run_op(3'(op), 6'(f), RW1, MW1, got, vld);
                check($sformatf("R2 %s f=%0d op=%0d", req_of(3'(op), got[WORD_W]), f, op),
                      got, ref_model(3'(op), 6'(f), RW1, MW1));
            end
        end

        // R9: idle cycles keep the result and drop valid
        run_op(3'd2, 6'd13, RW1, MW0, got, vld);
        held = got;
        op_sel = 3'd0; fsel = 6'd5; reg_in = RW0; mem_in = MW1;
        repeat (3) @(negedge clk);
        check("R9", {bad_field, result}, held);
        check("R9", {31'd0, valid}, '0);

        // R10: reset after activity clears outputs
        run_op(3'd0, 6'd54, RW0, MW0, got, vld);
        rst = 1'b1;
        @(negedge clk);
        check("R10", {valid, bad_field, result}, '0);
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule